// File: doc/BRIEF.md
# Gated Interrupt Aggregation Controller

This block collects interrupt requests from several places into one 32-bit primary pending register and drives a single interrupt line. Three secondary groups (a USB core group, a DMA group and a general-purpose group) each keep their own 32-bit pending and mask registers. The USB core group folds into two primary bits, one for its lower half and one for its upper half. The DMA group folds into one primary bit. Up to eight level-sensitive hardware sources write their level straight into the matching low primary bits whenever that level changes.

Software reaches every group through a word-addressed register port. Each group has a status view, a write-one-to-set address, a write-one-to-clear address and a mask register in which a 1 blocks the bit. A control word selects the output polarity. A power input closes a gate that holds the interrupt line low after power-up until a programmable number of clock cycles has passed. A small state machine handles this with the states PS_OFF, PS_WAIT and PS_READY. PS_OFF moves to PS_WAIT when power is seen high. PS_WAIT returns to PS_OFF when power drops, and moves to PS_READY when the count expires with power still high. PS_READY returns to PS_OFF when power drops, and the gate stays open in that case.

Top module: `gated_irq_aggregator`

## Requirements
- R1: A write to a group's set address (word address group*4+1, groups: 0 primary, 1 USB core, 2 DMA, 3 general-purpose) ORs the written data into that group's pending register.
- R2: A write to a group's clear address (group*4+2) clears every pending bit that is 1 in the written data and leaves the other bits unchanged.
- R3: A write to a group's mask address (group*4+3) stores the data as that group's mask, and reading that address returns it. Reads of the status (group*4+0), set or clear address all return the group's pending register. Address 16 holds the control word. Any other address reads 0.
- R4: After any write to the USB core group, primary bit 9 equals the OR of core pending bits 15:0 that are unmasked, and primary bit 8 equals the OR of unmasked core pending bits 31:16.
- R5: After any write to the DMA group, primary bit 24 is 1 if any DMA pending bit is unmasked, and 0 otherwise.
- R6: With control bit 17 set to 1, the interrupt output is 1 when the gate is open and at least one primary pending bit is unmasked.
- R7: With control bit 17 set to 0, the interrupt output is 1 when the gate is open and no primary pending bit is unmasked.
- R8: When power is first sampled high in PS_OFF, the gate closes on that edge. It opens on the edge PWR_DELAY cycles later if power stayed high throughout, and while it is closed the output is 0.
- R9: Power dropping during PS_WAIT keeps the gate closed, and a later rise starts a new full delay. Power dropping in PS_READY leaves the gate open.
- R10: After reset the primary mask is all ones, all pending registers, the secondary masks and the control word are 0, the state is PS_OFF with the gate closed, and the output is 0.
- R11: When hardware source n (n < NUM_SRC, at most 8) changes level, primary bit n takes the new level.
- R12: The interrupt output is registered and reflects a register write or a source change on the clock edge that accepts it.
- R13: The general-purpose group has pending and mask registers but no effect on the primary register or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for a write or read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_src | input | NUM_SRC | Level-sensitive hardware sources |
| pwr_on | input | 1 | Power-good level |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with PWR_DELAY set to 20 cycles instead of the long default. This keeps the whole power-up window, a power drop in the middle of the wait, and a full restart of the delay within a few hundred cycles. NUM_SRC stays at 8, so hardware sources share the low byte of the primary register with the software-set bits. That allows a check that the folded core and DMA bits above them are never disturbed by a source change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int NUM_GROUPS = 4;
    localparam int GRP_SEL_W  = $clog2(NUM_GROUPS);

    // primary bits fed by folded groups; neighbours decode these positions
    localparam int BIT_CORE_RX = 8;
    localparam int BIT_CORE_TX = 9;
    localparam int BIT_DMA     = 24;
    localparam int POL_BIT     = 17;
    localparam int MAX_SRC     = 8;

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(16);

    typedef enum logic [1:0] {
        GRP_PRIMARY = 2'd0,
        GRP_CORE    = 2'd1,
        GRP_DMA     = 2'd2,
        GRP_GPIO    = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        FN_STATUS = 2'd0,
        FN_SET    = 2'd1,
        FN_CLEAR  = 2'd2,
        FN_MASK   = 2'd3
    } fn_e;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_WAIT  = 2'd1,
        PS_READY = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_agg_pkg::*;
#(
    parameter int W = 32,
    parameter logic [W-1:0] MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         msk_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_val,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] live_d
);
    logic [W-1:0] pend_d;
    logic [W-1:0] mask_d;
    logic [W-1:0] pend_sw;

    always_comb begin
        pend_sw = pend_q;
        if (set_we) pend_sw = pend_sw | wdata;
        if (clr_we) pend_sw = pend_sw & ~wdata;
        pend_d = (pend_sw & ~ovr_en) | (ovr_val & ovr_en);
        mask_d = msk_we ? wdata : mask_q;
        live_d = pend_d & ~mask_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= MASK_RST;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

    a_r1_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pend_q & $past(wdata & ~ovr_en)) == $past(wdata & ~ovr_en)));

    a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(wdata & ~ovr_en)) == '0));

    a_r3_mask_stored: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/power_gate.sv
module power_gate
    import irq_agg_pkg::*;
#(
    parameter int PWR_DELAY = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic gate_q,
    output logic gate_d
);
    localparam int CNT_W = $clog2(PWR_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWR_DELAY - 1);

    pwr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic done;

    assign done = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:   if (pwr_on) state_d = PS_WAIT;
            PS_WAIT:  if (!pwr_on) state_d = PS_OFF;
                      else if (done) state_d = PS_READY;
            PS_READY: if (!pwr_on) state_d = PS_OFF;
            default:  state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_d = gate_q;
        if (state_q == PS_OFF && pwr_on)
            gate_d = 1'b0;
        else if (state_q == PS_WAIT && pwr_on && done)
            gate_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            gate_q <= gate_d;
            cnt_q  <= (state_q == PS_WAIT) ? cnt_q + 1'b1 : '0;
        end
    end

    a_r8_rise_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OFF && pwr_on) |=> (state_q == PS_WAIT && !gate_q));

    a_r9_wait_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_WAIT) |-> !gate_q);

    a_r9_ready_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_READY && !pwr_on) |=> (gate_q && state_q == PS_OFF));
endmodule

// File: rtl/gated_irq_aggregator.sv
module gated_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int PWR_DELAY = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_SRC-1:0] hw_src,
    input  logic              pwr_on,
    output logic              irq
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] pend_q [NUM_GROUPS];
    logic [DATA_W-1:0] mask_q [NUM_GROUPS];
    logic [DATA_W-1:0] live_d [NUM_GROUPS];
    logic [DATA_W-1:0] ovr_en  [NUM_GROUPS];
    logic [DATA_W-1:0] ovr_val [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_hit;

    logic              cfg_wr;
    logic [DATA_W-1:0] cfg_q, cfg_d;
    logic [NUM_SRC-1:0] src_prev;
    logic              gate_q, gate_d;
    logic              any_d, irq_d;

    grp_e grp_sel;
    fn_e  fn_sel;
    assign grp_sel = grp_e'(reg_addr[3:2]);
    assign fn_sel  = fn_e'(reg_addr[1:0]);
    assign cfg_wr  = reg_wr && (reg_addr == CFG_ADDR);

    // primary-bit overrides: source level changes and folded group summaries
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            ovr_en[g]  = '0;
            ovr_val[g] = '0;
        end
        ovr_en[0][NUM_SRC-1:0]  = hw_src ^ src_prev;
        ovr_val[0][NUM_SRC-1:0] = hw_src;
        if (grp_hit[GRP_CORE]) begin
            ovr_en[0][BIT_CORE_TX]  = 1'b1;
            ovr_en[0][BIT_CORE_RX]  = 1'b1;
            ovr_val[0][BIT_CORE_TX] = |live_d[GRP_CORE][HALF-1:0];
            ovr_val[0][BIT_CORE_RX] = |live_d[GRP_CORE][DATA_W-1:HALF];
        end
        if (grp_hit[GRP_DMA]) begin
            ovr_en[0][BIT_DMA]  = 1'b1;
            ovr_val[0][BIT_DMA] = |live_d[GRP_DMA];
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        assign grp_hit[g] = reg_wr && !reg_addr[4] && (reg_addr[3:2] == 2'(g));
        irq_bank #(
            .W        (DATA_W),
            .MASK_RST ((g == 0) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (grp_hit[g] && fn_sel == FN_SET),
            .clr_we  (grp_hit[g] && fn_sel == FN_CLEAR),
            .msk_we  (grp_hit[g] && fn_sel == FN_MASK),
            .wdata   (reg_wdata),
            .ovr_en  (ovr_en[g]),
            .ovr_val (ovr_val[g]),
            .pend_q  (pend_q[g]),
            .mask_q  (mask_q[g]),
            .live_d  (live_d[g])
        );
    end

    power_gate #(.PWR_DELAY(PWR_DELAY)) i_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_on (pwr_on),
        .gate_q (gate_q),
        .gate_d (gate_d)
    );

    always_comb begin
        cfg_d = cfg_wr ? reg_wdata : cfg_q;
        any_d = |live_d[GRP_PRIMARY];
        irq_d = gate_d & (cfg_d[POL_BIT] ? any_d : ~any_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            src_prev <= '0;
            irq      <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            src_prev <= hw_src;
            irq      <= irq_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CFG_ADDR)
            reg_rdata = cfg_q;
        else if (!reg_addr[4])
            reg_rdata = (fn_sel == FN_MASK) ? mask_q[grp_sel] : pend_q[grp_sel];
    end

    a_r4_core_fold: assert property (@(posedge clk) disable iff (!rst_n)
        grp_hit[GRP_CORE] |=>
            (pend_q[0][BIT_CORE_TX] == |(pend_q[1][HALF-1:0] & ~mask_q[1][HALF-1:0])) &&
            (pend_q[0][BIT_CORE_RX] == |(pend_q[1][DATA_W-1:HALF] & ~mask_q[1][DATA_W-1:HALF])));

    a_r5_dma_fold: assert property (@(posedge clk) disable iff (!rst_n)
        grp_hit[GRP_DMA] |=> (pend_q[0][BIT_DMA] == |(pend_q[2] & ~mask_q[2])));

    a_r8_gate_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> !irq);

    a_r6_pol_high: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && cfg_q[POL_BIT] && |(pend_q[0] & ~mask_q[0])) |-> irq);

    a_r7_pol_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q[POL_BIT] && |(pend_q[0] & ~mask_q[0])) |-> !irq);

    a_r11_src_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_q[0][NUM_SRC-1:0] & (src_prev ^ $past(src_prev)))
                         == (src_prev & (src_prev ^ $past(src_prev))));
endmodule

// File: tb/test_gated_irq_aggregator.sv
module test_gated_irq_aggregator;
    localparam int DLY = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  hw_src = '0;
    logic        pwr_on = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gated_irq_aggregator #(.NUM_SRC(8), .PWR_DELAY(DLY)) i_gated_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_src(hw_src),
        .pwr_on(pwr_on), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'd3, v);  chk("R10 primary mask", v, 32'hFFFF_FFFF);
        rd(5'd0, v);  chk("R10 primary pending", v, 32'h0);
        rd(5'd7, v);  chk("R10 core mask", v, 32'h0);
        rd(5'd16, v); chk("R10 control word", v, 32'h0);
        chk("R10 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        wr(5'd1, 32'h00F0_00F0);
        rd(5'd0, v);  chk("R1 primary set", v, 32'h00F0_00F0);
        wr(5'd2, 32'h0000_00F0);
        rd(5'd0, v);  chk("R2 primary clear", v, 32'h00F0_0000);
        rd(5'd1, v);  chk("R3 read via set address", v, 32'h00F0_0000);
        rd(5'd2, v);  chk("R3 read via clear address", v, 32'h00F0_0000);
        rd(5'd20, v); chk("R3 unmapped address", v, 32'h0);
        wr(5'd2, 32'hFFFF_FFFF);
        rd(5'd0, v);  chk("R2 clear all", v, 32'h0);
    endtask

    task automatic t_core_fold;
        logic [31:0] v;
        wr(5'd5, 32'h0001_0000);
        rd(5'd0, v);  chk("R4 upper half folds to bit 8", v, 32'h0000_0100);
        wr(5'd5, 32'h0000_0001);
        rd(5'd0, v);  chk("R4 lower half folds to bit 9", v, 32'h0000_0300);
        rd(5'd4, v);  chk("R1 core pending", v, 32'h0001_0001);
        wr(5'd7, 32'h0000_FFFF);
        rd(5'd7, v);  chk("R3 core mask readback", v, 32'h0000_FFFF);
        rd(5'd0, v);  chk("R4 masked lower half drops bit 9", v, 32'h0000_0100);
        wr(5'd6, 32'hFFFF_FFFF);
        rd(5'd0, v);  chk("R4 core clear drops both", v, 32'h0);
        wr(5'd7, 32'h0);
    endtask

    task automatic t_dma_fold;
        logic [31:0] v;
        wr(5'd9, 32'h0000_0004);
        rd(5'd0, v);  chk("R5 dma sets bit 24", v, 32'h0100_0000);
        wr(5'd11, 32'h0000_0004);
        rd(5'd0, v);  chk("R5 dma mask clears bit 24", v, 32'h0);
        wr(5'd11, 32'h0);
        rd(5'd0, v);  chk("R5 dma unmask restores bit 24", v, 32'h0100_0000);
        wr(5'd10, 32'h0000_0004);
        rd(5'd0, v);  chk("R5 dma clear drops bit 24", v, 32'h0);
    endtask

    task automatic t_powerup;
        @(negedge clk);
        pwr_on = 1'b1;
        cycles(DLY);
        chk("R8 gate still closed at delay edge minus one", {31'h0, irq}, 32'h0);
        cycles(1);
        chk("R8 gate opens after delay (R7 none pending)", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_polarity;
        wr(5'd3, 32'hFFEF_FFFF);
        chk("R7 unmask with nothing pending", {31'h0, irq}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h0010_0000;
        #1;
        chk("R12 irq unchanged before edge", {31'h0, irq}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R12 R7 irq drops on accepting edge", {31'h0, irq}, 32'h0);
        wr(5'd16, 32'h0002_0000);
        chk("R6 high polarity with pending bit", {31'h0, irq}, 32'h1);
        wr(5'd2, 32'h0010_0000);
        chk("R6 high polarity nothing pending", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_gpio;
        logic [31:0] v;
        wr(5'd13, 32'hFFFF_FFFF);
        rd(5'd12, v); chk("R13 gpio pending stored", v, 32'hFFFF_FFFF);
        rd(5'd0, v);  chk("R13 primary untouched", v, 32'h0);
        chk("R13 irq untouched", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_sources;
        logic [31:0] v;
        @(negedge clk); hw_src[3] = 1'b1;
        @(negedge clk);
        rd(5'd0, v);  chk("R11 source 3 sets bit 3", v, 32'h0000_0008);
        wr(5'd3, 32'hFFEF_FFF7);
        chk("R11 R6 unmasked source raises irq", {31'h0, irq}, 32'h1);
        @(negedge clk); hw_src[3] = 1'b0;
        @(negedge clk);
        rd(5'd0, v);  chk("R11 source 3 clears bit 3", v, 32'h0);
        chk("R11 irq drops with source", {31'h0, irq}, 32'h0);
        @(negedge clk); hw_src[3] = 1'b1;
        @(negedge clk);
        chk("R11 irq rises again", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_power_cycles;
        @(negedge clk); pwr_on = 1'b0;
        cycles(3);
        chk("R9 drop when ready keeps gate", {31'h0, irq}, 32'h1);
        pwr_on = 1'b1;
        cycles(1);
        chk("R8 rise closes gate", {31'h0, irq}, 32'h0);
        cycles(4);
        pwr_on = 1'b0;
        cycles(DLY + 5);
        chk("R9 drop during wait keeps gate closed", {31'h0, irq}, 32'h0);
        pwr_on = 1'b1;
        cycles(DLY);
        chk("R9 restart needs full delay", {31'h0, irq}, 32'h0);
        cycles(1);
        chk("R8 reopens after full delay", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_set_clear();
        t_core_fold();
        t_dma_fold();
        t_powerup();
        t_polarity();
        t_gpio();
        t_sources();
        t_power_cycles();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule